// File: doc/BRIEF.md
# Regulator Start-Up Sequencer

This block carries a multiphase buck regulator controller from power-on to a declared good output. It waits for the enable input and the supply lockout to both be clear, then for one externally timed delay interval. It then starts the switching oscillator and opens a short window in which the controller works out how many phases are fitted. Only after that does it enable soft start and drive a digital reference code that climbs from zero to a fixed boot level.

At the boot level the sequencer pauses so the processor's voltage-identification lines can settle. It then slews the reference, up or down, to the code the processor asks for. Once the analog side reports that the output has arrived, a final timed interval runs and power-good is raised. Losing enable or the lockout-clear condition at any point sends the sequence back to the start. Reference codes are linear: code k stands for k × 12.5 mV. The default boot code of 88 is therefore 1.1 V.

All intervals are counted in clocks of the block's own clock. The reference moves by one code every `STEP_CLKS` clocks.

Top module: `vreg_startup_seq`

## Requirements
- R1: After reset, and for as long as `en` or `uvlo_ok` is low, the outputs `osc_en`, `phase_det`, `ss_en` and `pgood` are 0 and `ref_code` is 0.
- R2: `osc_en` rises on the first clock edge at which `delay_done` is sampled high with `en` and `uvlo_ok` both already high. A `delay_done` pulse seen while the sequencer is idle does not count.
- R3: `phase_det` is high for exactly `DET_CYC` clocks (default 2), beginning with the rise of `osc_en`. During that window `ss_en` is 0 and `ref_code` stays 0.
- R4: `ss_en` rises when `phase_det` falls. `ref_code` then increases by exactly 1 every `STEP_CLKS` clocks and stops on `BOOT_CODE` without passing it.
- R5: After `ref_code` reaches `BOOT_CODE`, its next change occurs exactly `HOLD_CYC + STEP_CLKS + 1` clocks later.
- R6: After the hold, `ref_code` moves by 1 every `STEP_CLKS` clocks toward `vid_code`: upward if `vid_code` is above `BOOT_CODE`, downward if it is below. It stops exactly on `vid_code`.
- R7: `pgood` stays 0 until `out_at_target` is seen high while `ref_code` equals `vid_code`. It then rises on the `PGOOD_DLY + 1`-th clock edge counted from the edge that samples `out_at_target` high.
- R8: When `en` or `uvlo_ok` is sampled low in any state, then after that clock edge all outputs are 0, including `ref_code`. A fresh `delay_done` strobe is needed to restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Controller enable |
| uvlo_ok | input | 1 | Supply above lockout threshold |
| delay_done | input | 1 | One-clock strobe marking the end of the start delay |
| vid_code | input | 8 | Final target code from the processor |
| out_at_target | input | 1 | Output voltage has reached the reference |
| osc_en | output | 1 | Oscillator enable |
| phase_det | output | 1 | Phase-detection window |
| ss_en | output | 1 | Soft-start enable |
| ref_code | output | 8 | Digital reference code |
| pgood | output | 1 | Power-good |

## Verification
The bench builds the sequencer with `STEP_CLKS` = 3, `BOOT_CODE` = 20, `HOLD_CYC` = 10 and `PGOOD_DLY` = 7, keeping `DET_CYC` at 2. These small values make every step spacing, the hold length and the power-good latency countable clock by clock. A full sequence then completes in a few hundred cycles. With a boot code of 20, targets both above (30) and below (12) the boot level can be reached quickly, so both slew directions are covered. There is also room to drop the enables in mid-ramp and after power-good.

// File: rtl/vreg_seq_pkg.sv
package vreg_seq_pkg;

    localparam int CODE_W = 8;
    typedef logic [CODE_W-1:0] code_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DELAY,
        ST_DETECT,
        ST_RAMP_BOOT,
        ST_HOLD,
        ST_RAMP_VID,
        ST_SETTLE,
        ST_PG_WAIT,
        ST_GOOD
    } seq_state_e;

    typedef struct packed {
        logic osc;
        logic det;
        logic ss;
        logic good;
    } seq_out_t;

    function automatic seq_out_t decode_outputs(seq_state_e s);
        seq_out_t o;
        o.osc  = (s != ST_IDLE) && (s != ST_DELAY);
        o.det  = (s == ST_DETECT);
        o.ss   = (s >= ST_RAMP_BOOT);
        o.good = (s == ST_GOOD);
        return o;
    endfunction

    function automatic code_t step_toward(code_t cur, code_t tgt);
        if (cur < tgt)      return cur + 1'b1;
        else if (cur > tgt) return cur - 1'b1;
        else                return cur;
    endfunction

endpackage

// File: rtl/vreg_seq_timer.sv
module vreg_seq_timer #(
    parameter int TMR_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic [TMR_W-1:0] limit,
    output logic             expired
);
    logic [TMR_W-1:0] cnt;

    assign expired = (cnt >= limit - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || restart) cnt <= '0;
        else if (!expired)  cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/vreg_seq_ramp.sv
module vreg_seq_ramp
    import vreg_seq_pkg::*;
#(
    parameter int STEP_CLKS = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  clear,
    input  logic  active,
    input  code_t target,
    output code_t ref_code,
    output logic  at_target
);
    localparam int SC_W = $clog2(STEP_CLKS + 1);
    localparam logic [SC_W-1:0] STEP_LAST = SC_W'(STEP_CLKS - 1);

    logic [SC_W-1:0] step_cnt;

    assign at_target = (ref_code == target);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            ref_code <= '0;
            step_cnt <= '0;
        end else if (!active || at_target) begin
            step_cnt <= '0;
        end else if (step_cnt == STEP_LAST) begin
            step_cnt <= '0;
            ref_code <= step_toward(ref_code, target);
        end else begin
            step_cnt <= step_cnt + 1'b1;
        end
    end

    // R4
    hold_on_target_chk: assert property (@(posedge clk) disable iff (rst)
        (active && !clear && at_target) |=> (ref_code == $past(ref_code)));

    // R6
    unit_step_chk: assert property (@(posedge clk) disable iff (rst)
        !clear |=> ((code_t'(ref_code - $past(ref_code)) == code_t'(0)) ||
                    (code_t'(ref_code - $past(ref_code)) == code_t'(1)) ||
                    (code_t'(ref_code - $past(ref_code)) == '1)));
endmodule

// File: rtl/vreg_seq_fsm.sv
module vreg_seq_fsm
    import vreg_seq_pkg::*;
#(
    parameter int TMR_W     = 8,
    parameter int DET_CYC   = 2,
    parameter int HOLD_CYC  = 100,
    parameter int PGOOD_DLY = 50
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_ok,
    input  logic             delay_done,
    input  logic             ref_at_target,
    input  logic             out_at_target,
    input  logic             tmr_expired,
    output seq_state_e       state,
    output logic             tmr_restart,
    output logic [TMR_W-1:0] tmr_limit
);
    seq_state_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:      nxt = ST_DELAY;
            ST_DELAY:     if (delay_done) nxt = ST_DETECT;
            ST_DETECT:    if (tmr_expired) nxt = ST_RAMP_BOOT;
            ST_RAMP_BOOT: if (ref_at_target) nxt = ST_HOLD;
            ST_HOLD:      if (tmr_expired) nxt = ST_RAMP_VID;
            ST_RAMP_VID:  if (ref_at_target) nxt = ST_SETTLE;
            ST_SETTLE:    if (out_at_target && ref_at_target) nxt = ST_PG_WAIT;
            ST_PG_WAIT:   if (tmr_expired) nxt = ST_GOOD;
            ST_GOOD:      nxt = ST_GOOD;
            default:      nxt = ST_IDLE;
        endcase
        if (!run_ok) nxt = ST_IDLE;
    end

    always_comb begin
        unique case (state)
            ST_DETECT:  tmr_limit = TMR_W'(DET_CYC);
            ST_HOLD:    tmr_limit = TMR_W'(HOLD_CYC);
            ST_PG_WAIT: tmr_limit = TMR_W'(PGOOD_DLY);
            default:    tmr_limit = TMR_W'(1);
        endcase
    end

    assign tmr_restart = (nxt != state);

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    // R2
    osc_after_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DETECT && $past(state) != ST_DETECT) |-> $past(delay_done));

    // R7
    pgood_after_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_GOOD && $past(state) != ST_GOOD) |-> $past(state) == ST_PG_WAIT);
endmodule

// File: rtl/vreg_startup_seq.sv
module vreg_startup_seq
    import vreg_seq_pkg::*;
#(
    parameter int STEP_CLKS = 4,
    parameter int BOOT_CODE = 88,
    parameter int DET_CYC   = 2,
    parameter int HOLD_CYC  = 1000,
    parameter int PGOOD_DLY = 500
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       uvlo_ok,
    input  logic       delay_done,
    input  logic [7:0] vid_code,
    input  logic       out_at_target,
    output logic       osc_en,
    output logic       phase_det,
    output logic       ss_en,
    output logic [7:0] ref_code,
    output logic       pgood
);
    localparam int MAX_LIM = (HOLD_CYC > PGOOD_DLY) ?
                             ((HOLD_CYC > DET_CYC) ? HOLD_CYC : DET_CYC) :
                             ((PGOOD_DLY > DET_CYC) ? PGOOD_DLY : DET_CYC);
    localparam int TMR_W = $clog2(MAX_LIM + 1);

    seq_state_e       state;
    seq_out_t         outs;
    logic             run_ok, tmr_restart, tmr_expired, at_tgt, ramp_active;
    logic [TMR_W-1:0] tmr_limit;
    code_t            ramp_tgt;

    assign run_ok      = en && uvlo_ok;
    assign outs        = decode_outputs(state);
    assign ramp_active = outs.ss;
    assign ramp_tgt    = (state == ST_RAMP_BOOT || state == ST_HOLD) ?
                         code_t'(BOOT_CODE) : vid_code;

    vreg_seq_fsm #(
        .TMR_W(TMR_W), .DET_CYC(DET_CYC),
        .HOLD_CYC(HOLD_CYC), .PGOOD_DLY(PGOOD_DLY)
    ) u_fsm (
        .clk(clk), .rst(rst), .run_ok(run_ok), .delay_done(delay_done),
        .ref_at_target(at_tgt), .out_at_target(out_at_target),
        .tmr_expired(tmr_expired), .state(state),
        .tmr_restart(tmr_restart), .tmr_limit(tmr_limit)
    );

    vreg_seq_timer #(.TMR_W(TMR_W)) u_tmr (
        .clk(clk), .rst(rst), .restart(tmr_restart),
        .limit(tmr_limit), .expired(tmr_expired)
    );

    vreg_seq_ramp #(.STEP_CLKS(STEP_CLKS)) u_ramp (
        .clk(clk), .rst(rst), .clear(!run_ok || !ramp_active),
        .active(ramp_active), .target(ramp_tgt),
        .ref_code(ref_code), .at_target(at_tgt)
    );

    assign osc_en    = outs.osc;
    assign phase_det = outs.det;
    assign ss_en     = outs.ss;
    assign pgood     = outs.good;

    // R8
    abort_clears_chk: assert property (@(posedge clk) disable iff (rst)
        !run_ok |=> (ref_code == '0 && !pgood && !osc_en && !ss_en));

    // R3
    detect_ref_zero_chk: assert property (@(posedge clk) disable iff (rst)
        phase_det |-> (ref_code == '0 && osc_en));
endmodule

// File: tb/vreg_startup_seq_test.sv
module vreg_startup_seq_test;
    localparam int STEP = 3, BOOT = 20, DET = 2, HOLD = 10, PGD = 7;

    logic clk = 0, rst = 1, en = 0, uvlo_ok = 0, delay_done = 0, out_at_target = 0;
    logic [7:0] vid_code = 8'd30;
    logic osc_en, phase_det, ss_en, pgood;
    logic [7:0] ref_code;
    int checks = 0, fails = 0;
    bit finished = 0;

    vreg_startup_seq #(.STEP_CLKS(STEP), .BOOT_CODE(BOOT), .DET_CYC(DET),
                       .HOLD_CYC(HOLD), .PGOOD_DLY(PGD)) uut (
        .clk(clk), .rst(rst), .en(en), .uvlo_ok(uvlo_ok), .delay_done(delay_done),
        .vid_code(vid_code), .out_at_target(out_at_target), .osc_en(osc_en),
        .phase_det(phase_det), .ss_en(ss_en), .ref_code(ref_code), .pgood(pgood));

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic outs_zero(input string req);
        chk({osc_en, phase_det, ss_en, pgood} == 4'b0, req,
            {osc_en, phase_det, ss_en, pgood}, 0);
        chk(ref_code == 0, req, ref_code, 0);
    endtask

    // walk ref_code to tgt, checking unit steps and spacing; cnt0 = clocks already elapsed
    task automatic ramp_to(input int tgt, input int cnt0, input string req);
        int cnt = cnt0;
        int prev = ref_code;
        for (int g = 0; g < 2000 && ref_code != tgt; g++) begin
            @(negedge clk); cnt++;
            if (ref_code != prev) begin
                chk(cnt == STEP, req, cnt, STEP);
                chk(int'(ref_code) == prev + ((tgt > prev) ? 1 : -1), req, ref_code,
                    prev + ((tgt > prev) ? 1 : -1));
                prev = ref_code; cnt = 0;
            end
        end
        chk(ref_code == tgt, req, ref_code, tgt);
    endtask

    task automatic startup(input int vid);
        int n;
        @(negedge clk); en = 0;
        @(negedge clk); en = 1; uvlo_ok = 1; vid_code = 8'(vid); out_at_target = 0;
        repeat (4) @(negedge clk);
        chk(!osc_en, "R2", osc_en, 0);
        delay_done = 1; @(negedge clk); delay_done = 0;
        chk(osc_en && phase_det && !ss_en, "R2", {osc_en, phase_det, ss_en}, 3'b110);
        n = 1;
        while (phase_det && n < 50) begin
            chk(ref_code == 0 && !ss_en, "R3", ref_code, 0);
            @(negedge clk); if (phase_det) n++;
        end
        chk(n == DET, "R3", n, DET);
        chk(ss_en, "R4", ss_en, 1);
        ramp_to(BOOT, 0, "R4");
        n = 0;
        while (ref_code == BOOT && n < 500) begin @(negedge clk); n++; end
        chk(n == HOLD + STEP + 1, "R5", n, HOLD + STEP + 1);
        chk(int'(ref_code) == BOOT + ((vid > BOOT) ? 1 : -1), "R6", ref_code,
            BOOT + ((vid > BOOT) ? 1 : -1));
        ramp_to(vid, 0, "R6");
        repeat (3 * STEP) begin
            @(negedge clk);
            chk(ref_code == vid, "R6", ref_code, vid);
            chk(!pgood, "R7", pgood, 0);
        end
        out_at_target = 1;
        n = 0;
        while (!pgood && n < 500) begin @(negedge clk); n++; end
        chk(n == PGD + 1, "R7", n, PGD + 1);
    endtask

    task automatic t_reset_idle;
        @(negedge clk); outs_zero("R1");
        rst = 0;
        en = 1; repeat (3) @(negedge clk); outs_zero("R1");
        en = 0; uvlo_ok = 1; repeat (3) @(negedge clk); outs_zero("R1");
        uvlo_ok = 0; delay_done = 1; @(negedge clk); delay_done = 0;
        en = 1; uvlo_ok = 1; repeat (5) @(negedge clk);
        chk(!osc_en, "R2", osc_en, 0);
        en = 0; @(negedge clk);
    endtask

    task automatic t_abort;
        en = 1; uvlo_ok = 1; repeat (2) @(negedge clk);
        delay_done = 1; @(negedge clk); delay_done = 0;
        for (int g = 0; g < 200 && ref_code < 3; g++) @(negedge clk);
        uvlo_ok = 0; @(negedge clk);
        outs_zero("R8");
        uvlo_ok = 1; repeat (6) @(negedge clk);
        chk(!osc_en, "R8", osc_en, 0);
        startup(25);
        chk(pgood, "R7", pgood, 1);
        en = 0; @(negedge clk);
        outs_zero("R8");
    endtask

    initial begin
        t_reset_idle();
        startup(30);
        startup(12);
        t_abort();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule